// File: doc/BRIEF.md
# Interrupt Priority Mask Unit

This block keeps the 16-line interrupt block mask for a pair of cascaded 8-bit interrupt controllers. A set bit blocks its line. Software changes the mask in one of two ways.

A raise ORs one of several programmable device-class group masks into the current mask, so nested raises block the union of every group requested. An assign replaces the mask with an exact value, which is how a saved level is restored or every usable line is opened. Either operation reports the mask that was in force before it.

After each update the unit writes the low byte to the first controller and then the high byte to the second controller. Each write waits for its acknowledge. A busy flag holds the processor's interrupt acceptance off until both writes have landed, so the change looks atomic.

A separate register holds the lines with no device behind them. That unused-line mask is folded into every group at the moment it is used. Line 2 carries the second controller's cascade, so the unit never blocks it.

Top module: `ipm_unit`

## Requirements
- R1: After reset the mask is 0xFFFB, which blocks every line except cascade line 2. Busy is low and no controller write is pending.
- R2: A raise (op_kind=0) sets the new mask to old | group[op_grp] | unused. op_grp 0..4 selects a group register, and op_grp 5..7 contributes only the unused-line mask.
- R3: An assign (op_kind=1) sets the mask to op_value exactly, apart from bit 2. Assigning the unused-line mask leaves only the unused lines blocked.
- R4: old_mask shows the mask that was in force just before the latest accepted operation, and it holds until the next accepted operation.
- R5: Bits 7:0 of the new mask go out first on the low-controller write and are held until lo_wr_ack. Only after that are bits 15:8 presented on the high-controller write.
- R6: Bit 2 (the cascade line) is 0 in every mask the unit holds or writes, including the unused-line mask.
- R7: upd_busy is high from the cycle after an operation is accepted until the cycle in which the high-controller write is acknowledged, and it is low in the next cycle.
- R8: Configuration addresses 0..4 write the five group registers (block I/O, terminal, network, protocol, high) and address 5 writes the unused-line mask. The unused-line mask is applied to every group at the time of use, so a later change to it affects later raises.
- R9: An operation presented while upd_busy is high is not accepted and does not change the mask.
- R10: When a configuration write and a raise that selects the same group arrive in the same cycle, the raise uses the group's value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 3 | Configuration register index (0..4 groups, 5 unused lines) |
| cfg_wdata | input | 16 | Configuration write data |
| op_valid | input | 1 | Mask operation request |
| op_kind | input | 1 | 0 raise (OR group in), 1 assign exact value |
| op_grp | input | 3 | Group selected by a raise |
| op_value | input | 16 | Value for an assign |
| old_mask | output | 16 | Mask in force before the last accepted operation |
| cur_mask | output | 16 | Mask currently in force |
| upd_busy | output | 1 | Update in flight; interrupt acceptance must stay held off |
| lo_wr_valid | output | 1 | Low-controller mask write request |
| lo_wr_data | output | 8 | Low byte of the mask |
| lo_wr_ack | input | 1 | Low-controller write acknowledge |
| hi_wr_valid | output | 1 | High-controller mask write request |
| hi_wr_data | output | 8 | High byte of the mask |
| hi_wr_ack | input | 1 | High-controller write acknowledge |

## Verification
Two pairs of functions can meet in one cycle. The first is a group configuration write and a raise that reads the same group. The bench drives both in one cycle and expects the controller writes to carry the pre-write group value, then expects the next raise of that group to carry the new value. The second is a new operation request and an update still in flight. The bench asserts a raise of the all-blocking group while busy is high, and then reads the old value returned by the following assign to show that the mask did not move. Acknowledge delays are varied so that the busy window covers several cycles.

// File: rtl/ipm_pkg.sv
package ipm_pkg;
  localparam int unsigned IPM_W = 16;
  localparam int unsigned IPM_BYTE = IPM_W / 2;

  typedef logic [IPM_W-1:0] imask_t;

  typedef enum logic {
    OP_RAISE  = 1'b0,
    OP_ASSIGN = 1'b1
  } op_kind_e;

  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_LO   = 2'd1,
    WR_HI   = 2'd2
  } wr_state_e;

  // Clear the cascade line so the second controller stays reachable.
  function automatic imask_t open_line(imask_t m, int unsigned b);
    imask_t r;
    r = m;
    r[b] = 1'b0;
    return r;
  endfunction

  function automatic imask_t merge_raise(imask_t cur, imask_t grp_eff, int unsigned casc);
    return open_line(cur | grp_eff, casc);
  endfunction

  function automatic imask_t exact_assign(imask_t v, int unsigned casc);
    return open_line(v, casc);
  endfunction
endpackage

// File: rtl/ipm_group_bank.sv
module ipm_group_bank
  import ipm_pkg::*;
#(
  parameter int unsigned N_GROUPS = 5,
  parameter int unsigned CASC_BIT = 2,
  parameter int unsigned AW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  imask_t        cfg_wdata,
  input  logic [AW-1:0] rd_sel,
  output imask_t        grp_eff
);
  localparam logic [AW-1:0] UNUSED_ADDR = AW'(N_GROUPS);

  imask_t grp_q [N_GROUPS];
  imask_t unused_q;
  imask_t grp_pick;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        grp_q[g] <= '0;
      end else if (cfg_we && cfg_addr == AW'(g)) begin
        grp_q[g] <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unused_q <= open_line('1, CASC_BIT);
    end else if (cfg_we && cfg_addr == UNUSED_ADDR) begin
      unused_q <= open_line(cfg_wdata, CASC_BIT);
    end
  end

  always_comb begin
    grp_pick = '0;
    for (int i = 0; i < N_GROUPS; i++) begin
      if (rd_sel == AW'(i)) grp_pick = grp_q[i];
    end
  end

  // Unused lines are folded into whatever group is read.
  assign grp_eff = grp_pick | unused_q;

  assert_unused_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !unused_q[CASC_BIT]);
endmodule

// File: rtl/ipm_mask_core.sv
module ipm_mask_core
  import ipm_pkg::*;
#(
  parameter int unsigned CASC_BIT = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fire,
  input  op_kind_e kind,
  input  imask_t   grp_eff,
  input  imask_t   value,
  output imask_t   cur_mask,
  output imask_t   old_mask
);
  imask_t next_mask;

  always_comb begin
    if (kind == OP_RAISE) next_mask = merge_raise(cur_mask, grp_eff, CASC_BIT);
    else                  next_mask = exact_assign(value, CASC_BIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_mask <= open_line('1, CASC_BIT);
      old_mask <= open_line('1, CASC_BIT);
    end else if (fire) begin
      cur_mask <= next_mask;
      old_mask <= cur_mask;
    end
  end

  assert_raise_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && kind == OP_RAISE |=> (cur_mask & $past(cur_mask)) == $past(cur_mask));

  assert_assign_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && kind == OP_ASSIGN |=>
      (cur_mask | (IPM_W'(1) << CASC_BIT)) == ($past(value) | (IPM_W'(1) << CASC_BIT)));

  assert_old_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> old_mask == $past(cur_mask));

  assert_old_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(old_mask));

  assert_cascade_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_mask[CASC_BIT]);
endmodule

// File: rtl/ipm_ctrl_writer.sv
module ipm_ctrl_writer
  import ipm_pkg::*;
#(
  parameter int unsigned CASC_BIT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  imask_t              mask,
  output logic                lo_valid,
  output logic [IPM_BYTE-1:0] lo_data,
  input  logic                lo_ack,
  output logic                hi_valid,
  output logic [IPM_BYTE-1:0] hi_data,
  input  logic                hi_ack,
  output logic                busy
);
  wr_state_e state_q, state_d;
  logic lo_done, hi_done;

  assign lo_done = lo_valid && lo_ack;
  assign hi_done = hi_valid && hi_ack;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WR_IDLE: if (start)   state_d = WR_LO;
      WR_LO:   if (lo_done) state_d = WR_HI;
      WR_HI:   if (hi_done) state_d = WR_IDLE;
      default:              state_d = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= WR_IDLE;
    else        state_q <= state_d;
  end

  assign lo_valid = (state_q == WR_LO);
  assign hi_valid = (state_q == WR_HI);
  assign lo_data  = mask[IPM_BYTE-1:0];
  assign hi_data  = mask[IPM_W-1:IPM_BYTE];
  assign busy     = (state_q != WR_IDLE);

  assert_lo_then_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_valid) |-> $past(lo_done));

  assert_one_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lo_valid, hi_valid}));

  assert_lo_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lo_valid && !lo_ack |=> lo_valid && $stable(lo_data));

  assert_busy_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !hi_done |=> busy);

  assert_busy_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hi_done |=> !busy);

  if (CASC_BIT < IPM_BYTE) begin : g_casc_lo
    assert_lo_cascade_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lo_valid |-> !lo_data[CASC_BIT]);
  end else begin : g_casc_hi
    assert_hi_cascade_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hi_valid |-> !hi_data[CASC_BIT-IPM_BYTE]);
  end
endmodule

// File: rtl/ipm_unit.sv
module ipm_unit
  import ipm_pkg::*;
#(
  parameter int unsigned N_GROUPS = 5,
  parameter int unsigned CASC_BIT = 2,
  localparam int unsigned AW = $clog2(N_GROUPS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [IPM_W-1:0]    cfg_wdata,
  input  logic                op_valid,
  input  logic                op_kind,
  input  logic [AW-1:0]       op_grp,
  input  logic [IPM_W-1:0]    op_value,
  output logic [IPM_W-1:0]    old_mask,
  output logic [IPM_W-1:0]    cur_mask,
  output logic                upd_busy,
  output logic                lo_wr_valid,
  output logic [IPM_BYTE-1:0] lo_wr_data,
  input  logic                lo_wr_ack,
  output logic                hi_wr_valid,
  output logic [IPM_BYTE-1:0] hi_wr_data,
  input  logic                hi_wr_ack
);
  imask_t   grp_eff;
  logic     op_fire;
  op_kind_e kind_e;

  assign op_fire = op_valid && !upd_busy;
  assign kind_e  = op_kind_e'(op_kind);

  ipm_group_bank #(.N_GROUPS(N_GROUPS), .CASC_BIT(CASC_BIT), .AW(AW)) bank_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd_sel(op_grp), .grp_eff(grp_eff)
  );

  ipm_mask_core #(.CASC_BIT(CASC_BIT)) core_i (
    .clk(clk), .rst_n(rst_n), .fire(op_fire), .kind(kind_e),
    .grp_eff(grp_eff), .value(op_value), .cur_mask(cur_mask), .old_mask(old_mask)
  );

  ipm_ctrl_writer #(.CASC_BIT(CASC_BIT)) writer_i (
    .clk(clk), .rst_n(rst_n), .start(op_fire), .mask(cur_mask),
    .lo_valid(lo_wr_valid), .lo_data(lo_wr_data), .lo_ack(lo_wr_ack),
    .hi_valid(hi_wr_valid), .hi_data(hi_wr_data), .hi_ack(hi_wr_ack),
    .busy(upd_busy)
  );

  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && upd_busy |=> $stable(cur_mask));

  assert_accept_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire |=> upd_busy && lo_wr_valid);
endmodule

// File: tb/ipm_unit_tb_top.sv
module ipm_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        op_valid = 1'b0;
  logic        op_kind = 1'b0;
  logic [2:0]  op_grp = '0;
  logic [15:0] op_value = '0;
  logic [15:0] old_mask, cur_mask;
  logic        upd_busy, lo_wr_valid, hi_wr_valid;
  logic [7:0]  lo_wr_data, hi_wr_data;
  logic        lo_wr_ack = 1'b0;
  logic        hi_wr_ack = 1'b0;

  always #5 clk = ~clk;

  ipm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .op_valid(op_valid), .op_kind(op_kind),
    .op_grp(op_grp), .op_value(op_value), .old_mask(old_mask),
    .cur_mask(cur_mask), .upd_busy(upd_busy), .lo_wr_valid(lo_wr_valid),
    .lo_wr_data(lo_wr_data), .lo_wr_ack(lo_wr_ack), .hi_wr_valid(hi_wr_valid),
    .hi_wr_data(hi_wr_data), .hi_wr_ack(hi_wr_ack)
  );

  typedef struct packed { logic [15:0] old_v; logic [15:0] new_v; } exp_t;
  exp_t exp_q[$];

  int n_cmp = 0;
  int n_bad = 0;
  int ack_delay = 0;
  int lo_wait = 0;
  int hi_wait = 0;
  logic expect_idle = 1'b0;
  logic [15:0] mg [6];
  logic [15:0] m_cur = 16'hFFFB;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] eff(logic [2:0] sel);
    logic [15:0] g;
    g = (sel < 3'd5) ? mg[sel] : 16'h0000;
    return g | mg[5];
  endfunction

  // Monitor and controller responder: compares each landed update.
  always @(negedge clk) begin
    if (expect_idle) begin
      check("R7 busy low after high ack", {15'd0, upd_busy}, 16'd0);
      expect_idle = 1'b0;
    end
    if (lo_wr_valid && !lo_wr_ack) begin
      check("R5 high write waits for low ack", {15'd0, hi_wr_valid}, 16'd0);
      if (lo_wait >= ack_delay) begin
        if (exp_q.size() == 0) check("R5 unexpected low write", 16'd1, 16'd0);
        else check("R5 low byte", {8'd0, lo_wr_data}, {8'd0, exp_q[0].new_v[7:0]});
        lo_wr_ack = 1'b1;
        lo_wait = 0;
      end else lo_wait++;
    end else lo_wr_ack = 1'b0;
    if (hi_wr_valid && !hi_wr_ack) begin
      if (hi_wait >= ack_delay) begin
        if (exp_q.size() == 0) check("R5 unexpected high write", 16'd1, 16'd0);
        else begin
          check("R5 high byte", {8'd0, hi_wr_data}, {8'd0, exp_q[0].new_v[15:8]});
          check("R4 old mask", old_mask, exp_q[0].old_v);
          check("R7 busy during update", {15'd0, upd_busy}, 16'd1);
          void'(exp_q.pop_front());
        end
        hi_wr_ack = 1'b1;
        hi_wait = 0;
        expect_idle = 1'b1;
      end else hi_wait++;
    end else hi_wr_ack = 1'b0;
  end

  task automatic cfg(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    mg[a] = (a == 3'd5) ? (d & 16'hFFFB) : d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Driver: computes the expected mask, queues it, issues the operation.
  task automatic op(logic kind, logic [2:0] grp, logic [15:0] val,
                    logic with_cfg, logic [2:0] ca, logic [15:0] cd);
    exp_t e;
    @(negedge clk);
    while (upd_busy) @(negedge clk);
    e.old_v = m_cur;
    if (!kind) e.new_v = (m_cur | eff(grp)) & 16'hFFFB;
    else       e.new_v = val & 16'hFFFB;
    m_cur = e.new_v;
    exp_q.push_back(e);
    op_valid = 1'b1; op_kind = kind; op_grp = grp; op_value = val;
    if (with_cfg) begin
      cfg_we = 1'b1; cfg_addr = ca; cfg_wdata = cd;
      mg[ca] = (ca == 3'd5) ? (cd & 16'hFFFB) : cd;
    end
    @(negedge clk);
    op_valid = 1'b0; cfg_we = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 5; i++) mg[i] = 16'h0000;
    mg[5] = 16'hFFFB;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset mask", cur_mask, 16'hFFFB);
    check("R1 reset busy", {15'd0, upd_busy}, 16'd0);
    check("R1 no pending write", {14'd0, lo_wr_valid, hi_wr_valid}, 16'd0);

    // R8 configure groups and unused-line mask
    cfg(3'd0, 16'h00C0);
    cfg(3'd1, 16'h0118);
    cfg(3'd2, 16'h2200);
    cfg(3'd3, 16'h0001);
    cfg(3'd4, 16'hFFFF);
    cfg(3'd5, 16'h8800);

    // R3 full unblock: assign unused-line mask
    op(1'b1, 3'd0, 16'h8800, 1'b0, 3'd0, 16'h0);
    check("R3 unblock leaves unused lines", cur_mask, 16'h8800);
    // R2 nested raises accumulate
    op(1'b0, 3'd1, 16'h0, 1'b0, 3'd0, 16'h0);
    ack_delay = 2;
    op(1'b0, 3'd0, 16'h0, 1'b0, 3'd0, 16'h0);
    check("R2 nested union", cur_mask, 16'h89D8);
    // R6 high group cannot block the cascade line
    op(1'b0, 3'd4, 16'h0, 1'b0, 3'd0, 16'h0);
    check("R6 cascade open after high raise", cur_mask, 16'hFFFB);
    // R3 restore saved level
    ack_delay = 0;
    op(1'b1, 3'd0, 16'h89D8, 1'b0, 3'd0, 16'h0);
    // R6 assign with bit 2 set
    op(1'b1, 3'd0, 16'h0004, 1'b0, 3'd0, 16'h0);
    check("R6 assign clears cascade", cur_mask, 16'h0000);
    // R2 selector beyond groups uses unused mask only
    op(1'b0, 3'd6, 16'h0, 1'b0, 3'd0, 16'h0);

    // R9 request while busy is ignored
    ack_delay = 3;
    fork
      op(1'b0, 3'd3, 16'h0, 1'b0, 3'd0, 16'h0);
      begin
        repeat (3) @(negedge clk);
        check("R7 busy mid update", {15'd0, upd_busy}, 16'd1);
        op_valid = 1'b1; op_kind = 1'b0; op_grp = 3'd4;
        @(negedge clk);
        op_valid = 1'b0;
      end
    join
    ack_delay = 1;
    op(1'b1, 3'd0, 16'h0000, 1'b0, 3'd0, 16'h0);  // R9 via old value

    // R10 same-cycle write and raise of group 2
    op(1'b0, 3'd2, 16'h0, 1'b1, 3'd2, 16'h0040);
    check("R10 raise used pre-write group", cur_mask, 16'hAA00);
    op(1'b1, 3'd0, 16'h0000, 1'b0, 3'd0, 16'h0);
    op(1'b0, 3'd2, 16'h0, 1'b0, 3'd0, 16'h0);
    check("R10 later raise sees new group", cur_mask, 16'h8840);

    // R8 unused mask changed later is forced into raises
    cfg(3'd5, 16'h0306);
    op(1'b1, 3'd0, 16'h0000, 1'b0, 3'd0, 16'h0);
    op(1'b0, 3'd3, 16'h0, 1'b0, 3'd0, 16'h0);
    check("R8 new unused lines forced in", cur_mask, 16'h0303);

    repeat (4) @(negedge clk);
    check("R5 scoreboard drained", 16'(exp_q.size()), 16'd0);
    finish_run();
  end
endmodule